// File: doc/BRIEF.md
# Ping-Pong Waveform Playback Sequencer

This block plays a stored multichannel waveform from one of two sample banks. While it plays, a host writes the other bank. A scan counter steps from address 0 up to a host-programmed highest occupied address. After that address it either wraps to 0 for continuous playback or, in single-pass (burst) mode, stops. Each sample leaves on a valid/ready output stream. Each step of the scan is paced by a time base chosen from four sources: a fast internal divider, a slow internal divider, a bit toggled by software, or an external clock pin. The chosen source passes through a two-flop synchronizer and a rising-edge detector. Each detected edge is one tick.

Bank swaps and stops never cut a pass short. When the host flips the bank-select bit during playback, the block raises a wait-swap flag and goes on reading the old bank until the sample at the highest address has left. Only then does it exchange the banks. When the run request is withdrawn, the block enters a drain state, finishes the pass, and then stops. Starting needs a rising edge of the run request while the armed input is high. The run request is the host start bit, or the external trigger pin when external triggering is chosen.

On the output stream, a sample is held while `out_ready` is low. A tick that arrives while the held sample has not been taken is dropped: the scan does not advance on it. The consumer therefore sets the pace only by losing ticks, never by queuing them.

Top module: `wave_pingpong_seq`

## Requirements
- R1: When the block is settled, the bank being scanned is the complement of `ctl_bank_sel`: select 0 scans bank 1, and select 1 scans bank 0. Host writes always go to the bank that is not being scanned, so a write never changes a sample that is playing.
- R2: If `ctl_bank_sel` changes while the block is running, `state_flags[2]` (wait-swap) is 1 and the scanned bank stays the same until the sample at `hi_addr` has been produced. The next sample is address 0 of the other bank, and `state_flags[2]` then returns to 0. While stopped, a swap takes effect within 3 cycles.
- R3: `scan_bank` reports the bank actually being scanned (0 or 1). It can differ from the bank requested by `ctl_bank_sel`.
- R4: Withdrawing the run request while running sets `state_flags[1]` (drain) and clears `state_flags[0]`. The samples up to `hi_addr` are still produced, and then the block stops.
- R5: `stopped_flag` is 1 when neither running nor draining and 0 otherwise. `state_flags[1:0]` is never 2'b11.
- R6: With `mode_burst` = 1, a start produces exactly one pass, from address 0 to `hi_addr`, and then the block stops even though the run request stays high. `state_flags[3]` mirrors `mode_burst`.
- R7: With `mode_ext` = 1, the synchronized `ext_trig` pin is the run request and `ctl_start` has no effect. `state_flags[4]` mirrors `mode_ext`.
- R8: `clk_sel` picks the time base: 2'b11 fast divider, 2'b01 slow divider, 2'b10 the `soft_ck` bit, 2'b00 the `ext_ck` pin. Each rising edge of the selected source advances the scan by one sample.
- R9: The block starts, at address 0, only on a rising edge of the run request while `armed_in` = 1. `state_flags` uses these bits: 0 running, 1 drain, 2 wait-swap, 3 burst, 4 external trigger, 6 armed (mirrors `armed_in`). Bits 5 and 7 are 0, and all flags are 0 after reset with `armed_in` low.
- R10: `out_valid`, `out_data` and `out_addr` hold steady while `out_ready` = 0. Ticks that arrive while a sample is held are dropped.
- R11: A one-cycle `ctl_xrst` pulse stops the block, sets `scan_addr` to 0, sets `scan_bank` to the complement of `ctl_bank_sel`, and drops `out_valid`.
- R12: In continuous mode, the sample after address `hi_addr` is address 0. `scan_addr` never exceeds `hi_addr` while `hi_addr` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_start | input | 1 | Host run request |
| ctl_bank_sel | input | 1 | Host bank-select bit |
| ctl_xrst | input | 1 | Synchronous extended reset |
| mode_burst | input | 1 | 1 selects a single pass |
| mode_ext | input | 1 | 1 makes ext_trig the run request |
| armed_in | input | 1 | Ready-to-run qualifier |
| clk_sel | input | 2 | Time-base select |
| soft_ck | input | 1 | Software-toggled time base |
| ext_ck | input | 1 | External time base |
| ext_trig | input | 1 | External start/stop pin |
| hi_addr | input | 16 | Highest occupied address |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | AW | Host write address |
| host_wr_data | input | DW | Host write data (one bit per channel) |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Output sample accepted |
| out_data | output | DW | Output sample |
| out_addr | output | 16 | Address of output sample |
| scan_addr | output | 16 | Next address to scan |
| scan_bank | output | 1 | Bank being scanned |
| stopped_flag | output | 1 | 1 when stopped |
| state_flags | output | 8 | One-hot state and mode flags |

## Verification
The hardest situation to reach is a deferred swap that has to land at the right boundary. The select bit must flip in the middle of a pass, and the wait-swap flag must be seen while the old bank is still being read. The bench then has to confirm that the sample after `hi_addr` comes from the other bank at address 0.

To get there, the software time base is used: each pulse of `soft_ck` gives exactly one tick. The bench can therefore stop partway through a pass, flip the select bit, check the flags, and queue the exact mixed sequence of old-bank and new-bank samples. Holding `out_ready` low across several pulses likewise exercises tick dropping under back-pressure.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic [1:0] {
    RUN_IDLE   = 2'd0,
    RUN_ACTIVE = 2'd1,
    RUN_DRAIN  = 2'd2
  } run_state_e;

  localparam logic [1:0] TB_EXT  = 2'b00;
  localparam logic [1:0] TB_SLOW = 2'b01;
  localparam logic [1:0] TB_SOFT = 2'b10;
  localparam logic [1:0] TB_FAST = 2'b11;

  localparam int FL_RUN   = 0;
  localparam int FL_DRAIN = 1;
  localparam int FL_WAIT  = 2;
  localparam int FL_BURST = 3;
  localparam int FL_EXT   = 4;
  localparam int FL_ARMED = 6;
endpackage

// File: rtl/wps_timebase.sv
module wps_timebase
  import wps_pkg::*;
#(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       soft_ck,
  input  logic       ext_ck,
  output logic       tick
);
  localparam int MAXD = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int CW   = $clog2(MAXD) + 1;

  logic [1:0] div_lvl;

  // two free-running square-wave dividers, half period = limit cycles
  for (genvar g = 0; g < 2; g++) begin : g_div
    localparam int LIM = (g == 0) ? FAST_DIV : SLOW_DIV;
    logic [CW-1:0] cnt;
    logic          lvl;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        lvl <= 1'b0;
      end else if (cnt == CW'(LIM - 1)) begin
        cnt <= '0;
        lvl <= ~lvl;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
    assign div_lvl[g] = lvl;
  end

  logic src;
  always_comb begin
    unique case (sel)
      TB_FAST: src = div_lvl[0];
      TB_SLOW: src = div_lvl[1];
      TB_SOFT: src = soft_ck;
      default: src = ext_ck;
    endcase
  end

  logic s1, s2, s3;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= src;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign tick = s2 & ~s3;
endmodule

// File: rtl/wps_bank_ram.sv
module wps_bank_ram #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] rd_bus [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
    end
    assign rd_bus[b] = mem[rd_addr];
  end

  assign rd_data = rd_bus[rd_bank];
endmodule

// File: rtl/wps_scan_ctrl.sv
module wps_scan_ctrl
  import wps_pkg::*;
#(
  parameter int DW     = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ctl_start,
  input  logic              ctl_bank_sel,
  input  logic              ctl_xrst,
  input  logic              mode_burst,
  input  logic              mode_ext,
  input  logic              armed_in,
  input  logic              ext_trig,
  input  logic [ADDR_W-1:0] hi_addr,
  input  logic [DW-1:0]     rd_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ADDR_W-1:0] scan_addr,
  output logic              scan_bank,
  output logic              stopped_flag,
  output logic [7:0]        state_flags
);
  run_state_e st;
  logic trig_s1, trig_s2, run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_s1 <= 1'b0;
      trig_s2 <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      trig_s1 <= ext_trig;
      trig_s2 <= trig_s1;
      run_q   <= run_req;
    end
  end

  logic run_req, run_rise, swap_pend, slot_free, adv, pass_end;
  assign run_req   = mode_ext ? trig_s2 : ctl_start;
  assign run_rise  = run_req & ~run_q;
  assign swap_pend = (scan_bank == ctl_bank_sel);
  assign slot_free = !out_valid || out_ready;
  assign adv       = tick && (st != RUN_IDLE) && slot_free;
  assign pass_end  = (scan_addr >= hi_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RUN_IDLE;
      scan_addr <= '0;
      scan_bank <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_addr  <= '0;
    end else if (ctl_xrst) begin
      st        <= RUN_IDLE;
      scan_addr <= '0;
      scan_bank <= ~ctl_bank_sel;
      out_valid <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (st == RUN_IDLE) begin
        if (swap_pend) scan_bank <= ~scan_bank;
        if (run_rise && armed_in) begin
          st        <= RUN_ACTIVE;
          scan_addr <= '0;
        end
      end else begin
        if (st == RUN_ACTIVE && !run_req) st <= RUN_DRAIN;
        if (adv) begin
          out_valid <= 1'b1;
          out_data  <= rd_data;
          out_addr  <= scan_addr;
          if (pass_end) begin
            scan_addr <= '0;
            if (swap_pend) scan_bank <= ~scan_bank;
            if (mode_burst || st == RUN_DRAIN || !run_req) st <= RUN_IDLE;
          end else begin
            scan_addr <= scan_addr + 1'b1;
          end
        end
      end
    end
  end

  assign stopped_flag = (st == RUN_IDLE);

  always_comb begin
    state_flags           = '0;
    state_flags[FL_RUN]   = (st == RUN_ACTIVE);
    state_flags[FL_DRAIN] = (st == RUN_DRAIN);
    state_flags[FL_WAIT]  = swap_pend && (st != RUN_IDLE);
    state_flags[FL_BURST] = mode_burst;
    state_flags[FL_EXT]   = mode_ext;
    state_flags[FL_ARMED] = armed_in;
  end
endmodule

// File: rtl/wave_pingpong_seq.sv
module wave_pingpong_seq
  import wps_pkg::*;
#(
  parameter int AW       = 5,
  parameter int DW       = 8,
  parameter int ADDR_W   = 16,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_start,
  input  logic              ctl_bank_sel,
  input  logic              ctl_xrst,
  input  logic              mode_burst,
  input  logic              mode_ext,
  input  logic              armed_in,
  input  logic [1:0]        clk_sel,
  input  logic              soft_ck,
  input  logic              ext_ck,
  input  logic              ext_trig,
  input  logic [ADDR_W-1:0] hi_addr,
  input  logic              host_wr_en,
  input  logic [AW-1:0]     host_wr_addr,
  input  logic [DW-1:0]     host_wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ADDR_W-1:0] scan_addr,
  output logic              scan_bank,
  output logic              stopped_flag,
  output logic [7:0]        state_flags
);
  logic          tick;
  logic [DW-1:0] rd_data;

  wps_timebase #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tb (
    .clk(clk), .rst_n(rst_n), .sel(clk_sel),
    .soft_ck(soft_ck), .ext_ck(ext_ck), .tick(tick)
  );

  wps_bank_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .wr_en(host_wr_en), .wr_bank(~scan_bank),
    .wr_addr(host_wr_addr), .wr_data(host_wr_data),
    .rd_bank(scan_bank), .rd_addr(scan_addr[AW-1:0]), .rd_data(rd_data)
  );

  wps_scan_ctrl #(.DW(DW), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ctl_start(ctl_start), .ctl_bank_sel(ctl_bank_sel), .ctl_xrst(ctl_xrst),
    .mode_burst(mode_burst), .mode_ext(mode_ext), .armed_in(armed_in),
    .ext_trig(ext_trig), .hi_addr(hi_addr), .rd_data(rd_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_addr(out_addr), .scan_addr(scan_addr), .scan_bank(scan_bank),
    .stopped_flag(stopped_flag), .state_flags(state_flags)
  );
endmodule

// File: rtl/wps_checker.sv
module wps_checker #(
  parameter int DW     = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_xrst,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DW-1:0]     out_data,
  input logic [ADDR_W-1:0] out_addr,
  input logic [ADDR_W-1:0] scan_addr,
  input logic [ADDR_W-1:0] hi_addr,
  input logic              scan_bank,
  input logic              stopped_flag,
  input logic [7:0]        state_flags
);
  // R5: never running and draining together; stopped means neither
  p_state_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(state_flags[1:0]) && (stopped_flag == (state_flags[1:0] == 2'b00)));

  // R2, R3: the scanned bank changes only while stopped or at a pass boundary
  p_swap_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_bank != $past(scan_bank)) && !$past(ctl_xrst)
      |-> $past(stopped_flag) || (scan_addr == '0));

  // R10: a held sample stays put until accepted
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !ctl_xrst
      |=> out_valid && $stable(out_data) && $stable(out_addr));

  // R11: extended reset stops and rewinds
  p_xrst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_xrst |=> stopped_flag && (scan_addr == '0) && !out_valid);

  // R12: scan stays inside the occupied range
  p_addr_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(hi_addr) && ($past(scan_addr) <= hi_addr) |-> scan_addr <= hi_addr);
endmodule

bind wave_pingpong_seq wps_checker #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_xrst(ctl_xrst),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_addr(out_addr), .scan_addr(scan_addr), .hi_addr(hi_addr),
  .scan_bank(scan_bank), .stopped_flag(stopped_flag), .state_flags(state_flags)
);

// File: tb/wave_pingpong_seq_tb_top.sv
module wave_pingpong_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int HI = 5;

  logic clk = 0, rst_n = 0;
  logic ctl_start = 0, ctl_bank_sel = 0, ctl_xrst = 0;
  logic mode_burst = 0, mode_ext = 0, armed_in = 0;
  logic [1:0] clk_sel = 2'b10;
  logic soft_ck = 0, ext_ck = 0, ext_trig = 0;
  logic [15:0] hi_addr = 16'(HI);
  logic host_wr_en = 0;
  logic [AW-1:0] host_wr_addr = '0;
  logic [DW-1:0] host_wr_data = '0;
  logic out_valid, out_ready = 1;
  logic [DW-1:0] out_data;
  logic [15:0] out_addr, scan_addr;
  logic scan_bank, stopped_flag;
  logic [7:0] state_flags;

  int total = 0, bad = 0;
  logic [23:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_pingpong_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .ctl_bank_sel(ctl_bank_sel),
    .ctl_xrst(ctl_xrst), .mode_burst(mode_burst), .mode_ext(mode_ext),
    .armed_in(armed_in), .clk_sel(clk_sel), .soft_ck(soft_ck), .ext_ck(ext_ck),
    .ext_trig(ext_trig), .hi_addr(hi_addr), .host_wr_en(host_wr_en),
    .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_addr(out_addr), .scan_addr(scan_addr), .scan_bank(scan_bank),
    .stopped_flag(stopped_flag), .state_flags(state_flags)
  );

  function automatic logic [7:0] pat_a(int a); return 8'(a * 3 + 1); endfunction
  function automatic logic [7:0] pat_b(int a); return 8'(a) ^ 8'hA5; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver side of the scoreboard
  task automatic push(input bit bank_b, input int a);
    expq.push_back({16'(a), bank_b ? pat_b(a) : pat_a(a)});
  endtask

  task automatic push_run(input bit bank_b, input int lo, input int hi);
    for (int a = lo; a <= hi; a++) push(bank_b, a);
  endtask

  task automatic pulse_soft(input int n);
    for (int i = 0; i < n; i++) begin
      soft_ck = 1; wait_cyc(4);
      soft_ck = 0; wait_cyc(4);
    end
  endtask

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      ext_ck = 1; wait_cyc(4);
      ext_ck = 0; wait_cyc(4);
    end
  endtask

  task automatic fill(input bit bank_b);
    for (int a = 0; a <= HI; a++) begin
      host_wr_en = 1; host_wr_addr = AW'(a);
      host_wr_data = bank_b ? pat_b(a) : pat_a(a);
      wait_cyc(1);
    end
    host_wr_en = 0;
    wait_cyc(1);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk(0, "R10 unexpected sample", int'({out_addr, out_data}), 0);
      end else begin
        logic [23:0] e;
        e = expq.pop_front();
        chk({out_addr, out_data} == e, "R8/R12 sample order", int'({out_addr, out_data}), int'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst_n = 1;
    wait_cyc(2);
    chk(stopped_flag == 1, "R5 reset stopped", stopped_flag, 1);
    chk(state_flags == 8'h00, "R9 reset flags", state_flags, 0);
    chk(out_valid == 0, "R10 reset valid", out_valid, 0);
    chk(scan_bank == 1, "R1 reset bank", scan_bank, 1);

    fill(0);                       // host bank is 0 while bank 1 is scanned
    ctl_bank_sel = 1; wait_cyc(3);
    chk(scan_bank == 0, "R1 swap while stopped", scan_bank, 0);
    chk(stopped_flag == 1, "R3 still stopped", stopped_flag, 1);
    fill(1);                       // host bank now 1

    // R9: start ignored when not armed
    ctl_start = 1; wait_cyc(3);
    pulse_soft(2);
    chk(stopped_flag == 1, "R9 unarmed start ignored", stopped_flag, 1);
    ctl_start = 0; armed_in = 1; wait_cyc(3);
    chk(state_flags == 8'h40, "R9 armed flag", state_flags, 8'h40);

    // continuous with wrap, then drain (R12, R4)
    ctl_start = 1; wait_cyc(4);
    chk(state_flags[0] == 1, "R9 running flag", state_flags, 8'h41);
    push_run(0, 0, HI); push_run(0, 0, 1);
    pulse_soft(8);
    ctl_start = 0; wait_cyc(4);
    chk(state_flags[1:0] == 2'b10, "R4 drain flag", state_flags[1:0], 2);
    chk(stopped_flag == 0, "R5 not stopped in drain", stopped_flag, 0);
    push_run(0, 2, HI);
    pulse_soft(4);
    wait_cyc(4);
    chk(stopped_flag == 1, "R4 stopped after pass", stopped_flag, 1);
    chk(scan_addr == 0, "R12 rewound", scan_addr, 0);

    // deferred swap (R2, R3)
    ctl_start = 1; wait_cyc(4);
    push_run(0, 0, 2);
    pulse_soft(3);
    ctl_bank_sel = 0; wait_cyc(4);
    chk(state_flags[2] == 1, "R2 wait-swap set", state_flags, 8'h45);
    chk(scan_bank == 0, "R3 bank held mid-pass", scan_bank, 0);
    push_run(0, 3, HI); push_run(1, 0, 1);
    pulse_soft(5);
    chk(scan_bank == 1, "R2 bank swapped at end", scan_bank, 1);
    chk(state_flags[2] == 0, "R2 wait-swap cleared", state_flags[2], 0);
    ctl_start = 0;
    push_run(1, 2, HI);
    pulse_soft(4);
    wait_cyc(4);
    chk(stopped_flag == 1, "R4 stopped", stopped_flag, 1);

    // back-pressure (R10)
    ctl_start = 1; wait_cyc(4);
    out_ready = 0;
    pulse_soft(3);
    chk(out_valid == 1 && out_addr == 0, "R10 held sample", out_addr, 0);
    push(1, 0);
    out_ready = 1; wait_cyc(2);
    push(1, 1);
    pulse_soft(1);
    ctl_start = 0;
    push_run(1, 2, HI);
    pulse_soft(4);
    wait_cyc(4);
    chk(stopped_flag == 1, "R10 stopped after pass", stopped_flag, 1);

    // burst (R6)
    mode_burst = 1; wait_cyc(2);
    chk(state_flags[3] == 1, "R6 burst flag", state_flags, 8'h48);
    ctl_start = 1; wait_cyc(4);
    push_run(1, 0, HI);
    pulse_soft(8);
    chk(stopped_flag == 1, "R6 single pass", stopped_flag, 1);
    ctl_start = 0;

    // fast and slow internal time bases (R8)
    clk_sel = 2'b11; wait_cyc(6);
    ctl_start = 1;
    push_run(1, 0, HI);
    wait_cyc(80);
    chk(stopped_flag == 1 && expq.size() == 0, "R8 fast pass done", expq.size(), 0);
    ctl_start = 0;
    clk_sel = 2'b01; wait_cyc(6);
    ctl_start = 1;
    push_run(1, 0, HI);
    wait_cyc(320);
    chk(stopped_flag == 1 && expq.size() == 0, "R8 slow pass done", expq.size(), 0);
    ctl_start = 0;

    // external clock and external trigger (R7, R8)
    clk_sel = 2'b00; mode_burst = 0; mode_ext = 1; wait_cyc(6);
    chk(state_flags[4] == 1, "R7 ext flag", state_flags, 8'h50);
    ctl_start = 1; wait_cyc(4);
    chk(stopped_flag == 1, "R7 host start ignored", stopped_flag, 1);
    ctl_start = 0;
    ext_trig = 1; wait_cyc(5);
    chk(state_flags[0] == 1, "R7 ext start", state_flags, 8'h51);
    push_run(1, 0, 1);
    pulse_ext(2);
    ext_trig = 0; wait_cyc(5);
    chk(state_flags[1] == 1, "R7 ext stop drains", state_flags, 8'h52);
    push_run(1, 2, HI);
    pulse_ext(4);
    wait_cyc(4);
    chk(stopped_flag == 1, "R7 stopped", stopped_flag, 1);
    mode_ext = 0; clk_sel = 2'b10; wait_cyc(6);

    // extended reset (R11)
    ctl_start = 1; wait_cyc(4);
    push_run(1, 0, 1);
    pulse_soft(2);
    ctl_xrst = 1; wait_cyc(1); ctl_xrst = 0; wait_cyc(1);
    chk(stopped_flag == 1, "R11 stopped", stopped_flag, 1);
    chk(scan_addr == 0, "R11 addr zero", scan_addr, 0);
    chk(scan_bank == 1, "R11 bank follows select", scan_bank, 1);
    ctl_start = 0;
    ctl_bank_sel = 1; wait_cyc(3);
    chk(scan_bank == 0, "R1 bank after select", scan_bank, 0);
    ctl_start = 1; wait_cyc(4);
    push(0, 0);
    pulse_soft(1);
    ctl_start = 0;
    push_run(0, 1, HI);
    pulse_soft(5);
    wait_cyc(4);
    chk(stopped_flag == 1 && expq.size() == 0, "R11 restart pass", expq.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule